// File: doc/BRIEF.md
# Time-Base and Watchdog Timer

This block turns a 32.768 kHz reference tick into three timed outputs: a programmable time-base square wave, a watchdog overflow flag and a selectable audio tone. It also drives an active-low interrupt line that reports time-base periods and watchdog overflow. The reference tick arrives as a one-cycle enable in the system clock domain.

Commands are single-cycle pulses that a decoder elsewhere produces. One command loads a 3-bit rate code that both the time-base and the watchdog use. Other commands enable, disable or clear the time-base and the watchdog, turn the interrupt on or off, and turn the tone on or off or set its pitch. All rates come from power-of-two division of the tick. When a rate code is loaded, the watchdog restarts its count.

Top module: `tick_timer_wdt`

## Requirements
- R1: After reset the time-base output and the watchdog flag are low, the interrupt output is high, the tone output is low, and the rate code is 7 (128 Hz).
- R2: Rate code k gives a time-base rate of 2^k Hz, which is a period of 2^(15-k) ticks. While the time-base is enabled, its output is low for the first half of each period and high for the second half.
- R3: While the time-base is disabled its output is low. A disable pulse takes priority over an enable pulse in the same cycle.
- R4: A clear-timer pulse zeroes the time-base phase. The output then rises 2^(14-k) ticks after the clear.
- R5: With the watchdog enabled, its flag sets exactly 4 selected periods, which is 2^(17-k) ticks, after the last clear, enable or rate load.
- R6: Once set, the watchdog flag stays high until a clear-watchdog or watchdog-disable pulse. A disable clears the count, and the count stands still while the watchdog is disabled.
- R7: A rate load changes the time-base rate in the next cycle and restarts the watchdog count from zero. It does not clear a flag that is already set.
- R8: While the interrupt is disabled, which is the reset state, the interrupt output stays high.
- R9: While the interrupt and the time-base are both enabled, the interrupt output goes low for one tick interval at the end of each time-base period.
- R10: While the interrupt is enabled and the watchdog flag output is high, the interrupt output is held low.
- R11: The tone output is low while the tone is off, which is the reset state. While it is on, it is a square wave of 8 ticks per period (4 kHz) after a fast-pitch pulse, or 16 ticks per period (2 kHz) after a slow-pitch pulse or reset.
- R12: Cycles without a tick advance none of the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle 32.768 kHz reference enable |
| rate_i | input | 3 | Rate code loaded by cmd_rate_i |
| cmd_rate_i | input | 1 | Load the rate code |
| cmd_tb_en_i | input | 1 | Enable the time-base output |
| cmd_tb_dis_i | input | 1 | Disable the time-base output |
| cmd_tb_clr_i | input | 1 | Zero the time-base phase |
| cmd_wd_en_i | input | 1 | Enable the watchdog |
| cmd_wd_dis_i | input | 1 | Disable the watchdog, clearing the flag and the count |
| cmd_wd_clr_i | input | 1 | Clear the watchdog flag and count |
| cmd_irq_en_i | input | 1 | Enable the interrupt output |
| cmd_irq_dis_i | input | 1 | Disable the interrupt output |
| cmd_tone_on_i | input | 1 | Turn the tone on |
| cmd_tone_off_i | input | 1 | Turn the tone off |
| cmd_tone_hi_i | input | 1 | Select the 4 kHz tone |
| cmd_tone_lo_i | input | 1 | Select the 2 kHz tone |
| tb_clk_o | output | 1 | Time-base square wave |
| wd_flag_o | output | 1 | Watchdog overflow flag |
| irq_n_o | output | 1 | Active-low interrupt |
| tone_o | output | 1 | Tone square wave |

## Verification
The assertions assume that every command is a single-cycle pulse and that the tick is a one-cycle enable. They also assume that a watchdog flag can only appear on a tick edge, because the count stands still while the watchdog is disabled. The stimulus never issues opposing commands in the same cycle and pulses each command for exactly one clock. It holds the tick high in every cycle except for one deliberate gap of ten cycles. This keeps every expected edge at a cycle the bench can compute from the last clear or rate load.

// File: rtl/tick_timer_wdt_pkg.sv
package tick_timer_wdt_pkg;

   // Mode bits held between commands.
   typedef struct packed {
      logic tb_en;
      logic wd_en;
      logic irq_en;
      logic tone_on;
      logic tone_fast;
   } mode_t;

   localparam mode_t MODE_RESET = '0;

   // Mask of the low counter bits that span one period for a given rate.
   function automatic logic [31:0] period_mask(input int unsigned width,
                                               input int unsigned code);
      logic [31:0] m;
      m = (32'd1 << width) - 32'd1;
      return m >> code;
   endfunction

endpackage

// File: rtl/tick_timer_wdt_modes.sv
module tick_timer_wdt_modes
   import tick_timer_wdt_pkg::*;
#(
   parameter int RATE_W     = 3,
   parameter int RESET_RATE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              cmd_rate_i,
   input  logic              cmd_tb_en_i,
   input  logic              cmd_tb_dis_i,
   input  logic              cmd_wd_en_i,
   input  logic              cmd_wd_dis_i,
   input  logic              cmd_irq_en_i,
   input  logic              cmd_irq_dis_i,
   input  logic              cmd_tone_on_i,
   input  logic              cmd_tone_off_i,
   input  logic              cmd_tone_hi_i,
   input  logic              cmd_tone_lo_i,
   output mode_t             mode_o,
   output logic [RATE_W-1:0] rate_o
);

   localparam logic [RATE_W-1:0] RATE_INIT = RATE_W'(RESET_RATE);

   mode_t             mode_q;
   logic [RATE_W-1:0] rate_q;

   // Where both commands arrive together, the "off" side wins.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         rate_q <= RATE_INIT;
      end else begin
         if (cmd_tb_dis_i)        mode_q.tb_en     <= 1'b0;
         else if (cmd_tb_en_i)    mode_q.tb_en     <= 1'b1;
         if (cmd_wd_dis_i)        mode_q.wd_en     <= 1'b0;
         else if (cmd_wd_en_i)    mode_q.wd_en     <= 1'b1;
         if (cmd_irq_dis_i)       mode_q.irq_en    <= 1'b0;
         else if (cmd_irq_en_i)   mode_q.irq_en    <= 1'b1;
         if (cmd_tone_off_i)      mode_q.tone_on   <= 1'b0;
         else if (cmd_tone_on_i)  mode_q.tone_on   <= 1'b1;
         if (cmd_tone_lo_i)       mode_q.tone_fast <= 1'b0;
         else if (cmd_tone_hi_i)  mode_q.tone_fast <= 1'b1;
         if (cmd_rate_i)          rate_q           <= rate_i;
      end
   end

   assign mode_o = mode_q;
   assign rate_o = rate_q;

endmodule

// File: rtl/tick_timer_wdt_timebase.sv
module tick_timer_wdt_timebase
   import tick_timer_wdt_pkg::*;
#(
   parameter int PRE_W  = 15,
   parameter int RATE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              clear_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              wave_o,
   output logic              period_end_o
);

   localparam int NUM_RATES = 1 << RATE_W;
   localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

   logic [PRE_W-1:0]     pre_q;
   logic [PRE_W-1:0]     mask;
   logic [NUM_RATES-1:0] taps;
   logic                 pend_q;

   // Rate k picks the prescaler bit that toggles 2^(k+1) times per second.
   for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
      assign taps[g] = pre_q[PRE_W-1-g];
   end

   assign mask = PRE_W'(period_mask(PRE_W, 32'(rate_i)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         pend_q <= 1'b0;
      end else if (clear_i) begin
         pre_q  <= '0;
         pend_q <= 1'b0;
      end else if (tick_i) begin
         pre_q  <= pre_q + ONE;
         pend_q <= ((pre_q & mask) == mask);
      end
   end

   assign wave_o       = taps[rate_i];
   assign period_end_o = pend_q;

endmodule

// File: rtl/tick_timer_wdt_watchdog.sv
module tick_timer_wdt_watchdog
   import tick_timer_wdt_pkg::*;
#(
   parameter int PRE_W           = 15,
   parameter int RATE_W          = 3,
   parameter int WD_PERIODS_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              enable_i,
   input  logic              clear_i,
   input  logic              restart_i,
   input  logic [RATE_W-1:0] rate_i,
   output logic              flag_o
);

   localparam int WD_W = PRE_W + WD_PERIODS_LOG2;
   localparam logic [WD_W-1:0] ONE = WD_W'(1);

   logic [WD_W-1:0] cnt_q;
   logic [WD_W-1:0] term;
   logic            flag_q;

   // The last count before overflow spans the requested number of periods.
   assign term = WD_W'(period_mask(WD_W, 32'(rate_i)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (clear_i) begin
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (restart_i) begin
         cnt_q  <= '0;
      end else if (tick_i && enable_i && !flag_q) begin
         if (cnt_q == term) begin
            cnt_q  <= '0;
            flag_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + ONE;
         end
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/tick_timer_wdt_tone.sv
module tick_timer_wdt_tone #(
   parameter int TONE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic fast_i,
   output logic wave_o
);

   localparam logic [TONE_W-1:0] ONE = TONE_W'(1);

   logic [TONE_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (tick_i) div_q <= div_q + ONE;
   end

   if (TONE_W == 1) begin : g_single
      assign wave_o = div_q[0];
   end else begin : g_dual
      assign wave_o = fast_i ? div_q[TONE_W-2] : div_q[TONE_W-1];
   end

endmodule

// File: rtl/tick_timer_wdt.sv
module tick_timer_wdt
   import tick_timer_wdt_pkg::*;
#(
   parameter int PRE_W           = 15,
   parameter int RATE_W          = 3,
   parameter int WD_PERIODS_LOG2 = 2,
   parameter int TONE_W          = 4,
   parameter int RESET_RATE      = (1 << RATE_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              cmd_rate_i,
   input  logic              cmd_tb_en_i,
   input  logic              cmd_tb_dis_i,
   input  logic              cmd_tb_clr_i,
   input  logic              cmd_wd_en_i,
   input  logic              cmd_wd_dis_i,
   input  logic              cmd_wd_clr_i,
   input  logic              cmd_irq_en_i,
   input  logic              cmd_irq_dis_i,
   input  logic              cmd_tone_on_i,
   input  logic              cmd_tone_off_i,
   input  logic              cmd_tone_hi_i,
   input  logic              cmd_tone_lo_i,
   output logic              tb_clk_o,
   output logic              wd_flag_o,
   output logic              irq_n_o,
   output logic              tone_o
);

   localparam int NUM_RATES = 1 << RATE_W;

   if (PRE_W < NUM_RATES) begin : g_chk_pre
      $error("PRE_W must cover one prescaler bit per rate code");
   end
   if (RESET_RATE >= NUM_RATES) begin : g_chk_rate
      $error("RESET_RATE lies outside the rate code range");
   end
   if (PRE_W + WD_PERIODS_LOG2 > 31) begin : g_chk_wd
      $error("watchdog counter too wide");
   end
   if (TONE_W < 1) begin : g_chk_tone
      $error("TONE_W must be at least 1");
   end

   mode_t             mode_q;
   logic [RATE_W-1:0] rate_q;
   logic              tb_wave;
   logic              tb_pend;
   logic              wd_raw;
   logic              tone_wave;

   tick_timer_wdt_modes #(
      .RATE_W     (RATE_W),
      .RESET_RATE (RESET_RATE)
   ) u_modes (
      .clk            (clk),
      .rst_n          (rst_n),
      .rate_i         (rate_i),
      .cmd_rate_i     (cmd_rate_i),
      .cmd_tb_en_i    (cmd_tb_en_i),
      .cmd_tb_dis_i   (cmd_tb_dis_i),
      .cmd_wd_en_i    (cmd_wd_en_i),
      .cmd_wd_dis_i   (cmd_wd_dis_i),
      .cmd_irq_en_i   (cmd_irq_en_i),
      .cmd_irq_dis_i  (cmd_irq_dis_i),
      .cmd_tone_on_i  (cmd_tone_on_i),
      .cmd_tone_off_i (cmd_tone_off_i),
      .cmd_tone_hi_i  (cmd_tone_hi_i),
      .cmd_tone_lo_i  (cmd_tone_lo_i),
      .mode_o         (mode_q),
      .rate_o         (rate_q)
   );

   tick_timer_wdt_timebase #(
      .PRE_W  (PRE_W),
      .RATE_W (RATE_W)
   ) u_timebase (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_i       (tick_i),
      .clear_i      (cmd_tb_clr_i),
      .rate_i       (rate_q),
      .wave_o       (tb_wave),
      .period_end_o (tb_pend)
   );

   tick_timer_wdt_watchdog #(
      .PRE_W           (PRE_W),
      .RATE_W          (RATE_W),
      .WD_PERIODS_LOG2 (WD_PERIODS_LOG2)
   ) u_watchdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .enable_i  (mode_q.wd_en),
      .clear_i   (cmd_wd_clr_i | cmd_wd_dis_i),
      .restart_i (cmd_rate_i),
      .rate_i    (rate_q),
      .flag_o    (wd_raw)
   );

   tick_timer_wdt_tone #(
      .TONE_W (TONE_W)
   ) u_tone (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .fast_i (mode_q.tone_fast),
      .wave_o (tone_wave)
   );

   assign tb_clk_o  = mode_q.tb_en & tb_wave;
   assign wd_flag_o = mode_q.wd_en & wd_raw;
   assign irq_n_o   = ~(mode_q.irq_en & ((mode_q.tb_en & tb_pend) | wd_flag_o));
   assign tone_o    = mode_q.tone_on & tone_wave;

endmodule

// File: rtl/tick_timer_wdt_chk.sv
module tick_timer_wdt_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_i,
   input logic cmd_any,
   input logic cmd_wd_clr_i,
   input logic cmd_wd_dis_i,
   input logic tb_en,
   input logic irq_en,
   input logic tone_on,
   input logic tb_clk_o,
   input logic wd_flag_o,
   input logic irq_n_o,
   input logic tone_o
);

   assert_tb_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_en |-> !tb_clk_o);

   assert_wd_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_flag_o) |-> $past(tick_i));

   assert_wd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wd_flag_o && !cmd_wd_clr_i && !cmd_wd_dis_i |=> wd_flag_o);

   assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> irq_n_o);

   assert_irq_wd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en && wd_flag_o |-> !irq_n_o);

   assert_tone_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !tone_on |-> !tone_o);

   assert_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !cmd_any |=> $stable(tb_clk_o) && $stable(tone_o) && $stable(wd_flag_o));

endmodule

bind tick_timer_wdt tick_timer_wdt_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_i       (tick_i),
   .cmd_any      (cmd_rate_i | cmd_tb_en_i | cmd_tb_dis_i | cmd_tb_clr_i |
                  cmd_wd_en_i | cmd_wd_dis_i | cmd_wd_clr_i | cmd_irq_en_i |
                  cmd_irq_dis_i | cmd_tone_on_i | cmd_tone_off_i |
                  cmd_tone_hi_i | cmd_tone_lo_i),
   .cmd_wd_clr_i (cmd_wd_clr_i),
   .cmd_wd_dis_i (cmd_wd_dis_i),
   .tb_en        (mode_q.tb_en),
   .irq_en       (mode_q.irq_en),
   .tone_on      (mode_q.tone_on),
   .tb_clk_o     (tb_clk_o),
   .wd_flag_o    (wd_flag_o),
   .irq_n_o      (irq_n_o),
   .tone_o       (tone_o)
);

// File: tb/tick_timer_wdt_bench.sv
`timescale 1ns/100ps
module tick_timer_wdt_bench;

   localparam logic [12:0] M_RATE    = 13'h0001;
   localparam logic [12:0] M_TBEN    = 13'h0002;
   localparam logic [12:0] M_TBDIS   = 13'h0004;
   localparam logic [12:0] M_TBCLR   = 13'h0008;
   localparam logic [12:0] M_WDEN    = 13'h0010;
   localparam logic [12:0] M_WDDIS   = 13'h0020;
   localparam logic [12:0] M_WDCLR   = 13'h0040;
   localparam logic [12:0] M_IRQEN   = 13'h0080;
   localparam logic [12:0] M_IRQDIS  = 13'h0100;
   localparam logic [12:0] M_TONEON  = 13'h0200;
   localparam logic [12:0] M_TONEOFF = 13'h0400;
   localparam logic [12:0] M_TONEHI  = 13'h0800;
   localparam logic [12:0] M_TONELO  = 13'h1000;

   localparam int S_TB = 0, S_WD = 1, S_IRQ = 2, S_TONE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic [2:0]  rate = 3'd7;
   logic [12:0] cmd = '0;
   logic        tb_clk, wd_flag, irq_n, tone;

   always #2.5 clk = ~clk;

   tick_timer_wdt u_tick_timer_wdt (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_i         (tick),
      .rate_i         (rate),
      .cmd_rate_i     (cmd[0]),
      .cmd_tb_en_i    (cmd[1]),
      .cmd_tb_dis_i   (cmd[2]),
      .cmd_tb_clr_i   (cmd[3]),
      .cmd_wd_en_i    (cmd[4]),
      .cmd_wd_dis_i   (cmd[5]),
      .cmd_wd_clr_i   (cmd[6]),
      .cmd_irq_en_i   (cmd[7]),
      .cmd_irq_dis_i  (cmd[8]),
      .cmd_tone_on_i  (cmd[9]),
      .cmd_tone_off_i (cmd[10]),
      .cmd_tone_hi_i  (cmd[11]),
      .cmd_tone_lo_i  (cmd[12]),
      .tb_clk_o       (tb_clk),
      .wd_flag_o      (wd_flag),
      .irq_n_o        (irq_n),
      .tone_o         (tone)
   );

   typedef struct {
      int    when;
      int    sig;
      logic  val;
      string tag;
   } item_t;

   item_t q[$];
   item_t mon_item;
   int    cyc = 0;
   int    checks = 0;
   int    fails = 0;
   int    base = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic sig_val(input int s);
      case (s)
         S_TB:    return tb_clk;
         S_WD:    return wd_flag;
         S_IRQ:   return irq_n;
         default: return tone;
      endcase
   endfunction

   function automatic string sig_name(input int s);
      case (s)
         S_TB:    return "tb_clk_o";
         S_WD:    return "wd_flag_o";
         S_IRQ:   return "irq_n_o";
         default: return "tone_o";
      endcase
   endfunction

   // Driver side: queue an expected output value for a given cycle.
   task automatic expect_at(input int when, input int sig, input logic val, input string tag);
      item_t it;
      int    pos;
      it.when = when; it.sig = sig; it.val = val; it.tag = tag;
      pos = q.size();
      for (int i = 0; i < q.size(); i++) begin
         if (q[i].when > when) begin
            pos = i;
            break;
         end
      end
      q.insert(pos, it);
   endtask

   // Monitor side: compare queued items when their cycle comes up.
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].when <= cyc) begin
         mon_item = q.pop_front();
         checks++;
         if (mon_item.when < cyc || sig_val(mon_item.sig) !== mon_item.val) begin
            fails++;
            $display("FAIL %s %s cycle %0d: actual %b expected %b", mon_item.tag,
                     sig_name(mon_item.sig), mon_item.when, sig_val(mon_item.sig), mon_item.val);
         end
      end
   end

   task automatic check_now(input string tag, input int sig, input logic val);
      checks++;
      if (sig_val(sig) !== val) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", tag, sig_name(sig), sig_val(sig), val);
      end
   endtask

   task automatic pulse(input logic [12:0] m, input logic [2:0] r);
      @(negedge clk);
      rate = r;
      cmd  = m;
      @(negedge clk);
      cmd  = '0;
      base = cyc;
   endtask

   task automatic wait_to(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic find_rise(output int r);
      logic prev;
      prev = tone;
      @(negedge clk);
      while (!(tone && !prev)) begin
         prev = tone;
         @(negedge clk);
      end
      r = cyc;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished run");
         summary();
         $finish;
      end
   end

   initial begin
      int r;
      int bd;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_now("R1", S_TB, 1'b0);
      check_now("R1", S_WD, 1'b0);
      check_now("R1", S_IRQ, 1'b1);
      check_now("R1", S_TONE, 1'b0);

      // R1 R2 R4: default 128 Hz, half period 128 ticks after a clear
      pulse(M_TBEN | M_TBCLR, 3'd7);
      expect_at(base + 127, S_TB, 1'b0, "R4");
      expect_at(base + 128, S_TB, 1'b1, "R1");
      expect_at(base + 255, S_TB, 1'b1, "R2");
      expect_at(base + 256, S_TB, 1'b0, "R2");
      expect_at(base + 256, S_IRQ, 1'b1, "R8");
      drain();

      // R3: disabled output stays low
      pulse(M_TBDIS | M_TBCLR, 3'd7);
      expect_at(base + 128, S_TB, 1'b0, "R3");
      expect_at(base + 200, S_TB, 1'b0, "R3");
      drain();

      // R12: ten missing ticks delay the rising edge by ten cycles
      pulse(M_TBEN | M_TBCLR, 3'd7);
      expect_at(base + 137, S_TB, 1'b0, "R12");
      expect_at(base + 138, S_TB, 1'b1, "R12");
      wait_to(base + 100);
      tick = 1'b0;
      wait_to(base + 110);
      tick = 1'b1;
      drain();

      // R5 R6: overflow after 1024 ticks at 128 Hz, then holds
      pulse(M_WDEN | M_WDCLR, 3'd7);
      expect_at(base + 1023, S_WD, 1'b0, "R5");
      expect_at(base + 1024, S_WD, 1'b1, "R5");
      expect_at(base + 1500, S_WD, 1'b1, "R6");
      drain();
      pulse(M_WDCLR, 3'd7);
      expect_at(base + 1, S_WD, 1'b0, "R6");
      expect_at(base + 1023, S_WD, 1'b0, "R5");
      expect_at(base + 1024, S_WD, 1'b1, "R5");
      drain();
      pulse(M_WDDIS, 3'd7);
      bd = base;
      expect_at(bd + 1, S_WD, 1'b0, "R6");
      wait_to(bd + 50);
      pulse(M_WDEN, 3'd7);
      expect_at(base + 1, S_WD, 1'b0, "R6");
      expect_at(base + 1023, S_WD, 1'b0, "R6");
      expect_at(base + 1024, S_WD, 1'b1, "R6");
      drain();

      // R7: rate load restarts the watchdog and changes the time-base at once
      pulse(M_WDCLR, 3'd7);
      wait_to(base + 500);
      pulse(M_RATE | M_TBCLR, 3'd6);
      expect_at(base + 255, S_TB, 1'b0, "R2");
      expect_at(base + 256, S_TB, 1'b1, "R7");
      expect_at(base + 512, S_TB, 1'b0, "R2");
      expect_at(base + 2047, S_WD, 1'b0, "R7");
      expect_at(base + 2048, S_WD, 1'b1, "R7");
      drain();
      pulse(M_RATE | M_TBCLR | M_WDCLR, 3'd5);
      expect_at(base + 511, S_TB, 1'b0, "R2");
      expect_at(base + 512, S_TB, 1'b1, "R2");
      expect_at(base + 1024, S_TB, 1'b0, "R2");
      expect_at(base + 4095, S_WD, 1'b0, "R5");
      expect_at(base + 4096, S_WD, 1'b1, "R5");
      drain();
      pulse(M_RATE | M_WDCLR, 3'd7);

      // R9: one-tick low pulse at each period end
      pulse(M_IRQEN | M_TBCLR | M_WDDIS, 3'd7);
      expect_at(base + 255, S_IRQ, 1'b1, "R9");
      expect_at(base + 256, S_IRQ, 1'b0, "R9");
      expect_at(base + 257, S_IRQ, 1'b1, "R9");
      expect_at(base + 512, S_IRQ, 1'b0, "R9");
      expect_at(base + 513, S_IRQ, 1'b1, "R9");
      drain();

      // R10: held low while the watchdog flag is up
      pulse(M_WDEN | M_WDCLR | M_TBDIS, 3'd7);
      expect_at(base + 1023, S_IRQ, 1'b1, "R10");
      expect_at(base + 1024, S_IRQ, 1'b0, "R10");
      expect_at(base + 1100, S_IRQ, 1'b0, "R10");
      drain();

      // R8: disabling the interrupt releases the line
      pulse(M_IRQDIS, 3'd7);
      expect_at(base + 1, S_IRQ, 1'b1, "R8");
      expect_at(base + 1, S_WD, 1'b1, "R6");
      drain();

      // R11: tone pitches and off state
      pulse(M_TONEON, 3'd7);
      find_rise(r);
      expect_at(r + 7, S_TONE, 1'b1, "R11");
      expect_at(r + 8, S_TONE, 1'b0, "R11");
      expect_at(r + 15, S_TONE, 1'b0, "R11");
      expect_at(r + 16, S_TONE, 1'b1, "R11");
      drain();
      pulse(M_TONEHI, 3'd7);
      find_rise(r);
      expect_at(r + 3, S_TONE, 1'b1, "R11");
      expect_at(r + 4, S_TONE, 1'b0, "R11");
      expect_at(r + 7, S_TONE, 1'b0, "R11");
      expect_at(r + 8, S_TONE, 1'b1, "R11");
      drain();
      pulse(M_TONEOFF, 3'd7);
      expect_at(base + 1, S_TONE, 1'b0, "R11");
      expect_at(base + 5, S_TONE, 1'b0, "R11");
      expect_at(base + 9, S_TONE, 1'b0, "R11");
      expect_at(base + 13, S_TONE, 1'b0, "R11");
      drain();

      done = 1'b1;
      summary();
      $finish;
   end

endmodule